// File: doc/BRIEF.md
# Programmable Video Display Timing Generator

This block produces the raster timing for a video output path. A horizontal counter steps through the pixels of a line and a vertical counter steps through the lines of a field. All frame geometry comes from configuration inputs: line length, the line counts of the two fields, sync and blanking placement, and pulse widths. Progressive formats use one field per frame. Interlaced formats use two fields, and the two fields may have different line counts.

The outputs are a dedicated horizontal sync, a vertical sync and a field identifier, together with a composite sync and an active-video enable. The dedicated syncs and the composite sync are all produced at once, and each has its own polarity control. The composite sync follows one of three timing families. One family uses plain OR-ed syncs. One uses broad pulses with serration during vertical sync. One adds equalization lines before and after vertical sync.

In master mode the counters run freely. In slave mode, a rising edge on the external horizontal input or the external vertical input reloads the matching counter with a programmed delay. The field input, sampled on the vertical edge, chooses the field. If no vertical edge arrives within one programmed frame of lines, a sticky lock-lost flag is raised and the counters keep running. The configuration is copied into a shadow set once after reset and then at every frame end, so a change made mid-frame takes effect only on the next frame.

Top module: `vtg_core`

## Requirements
- R1: The pixel counter runs from 0 to h_total_i-1 and wraps. The line counter advances on each wrap and returns to 0 after the last line of the current field.
- R2: With interlace_i=1 the fields alternate, field 0 lasting f1_lines_i lines and field 1 lasting f2_lines_i lines, and fid_o shows the field (0 or 1). With interlace_i=0 every field uses f1_lines_i and fid_o stays 0.
- R3: hs_o is active while pixel is in [hs_start_i, hs_start_i+hs_width_i). vs_o is active while line is in [vs_start_i, vs_start_i+vs_lines_i). Each is inverted when pol_i[0] (hs) or pol_i[1] (vs) is 1.
- R4: de_o is 1 exactly when pixel is in [h_act_start_i, h_act_end_i) and line is in [v_act_start_i, v_act_end_i).
- R5: cs_o follows mode_i: 0 gives broad pulses on vsync lines and hsync elsewhere; 1 is the same plus equalization lines; 2 or 3 gives the OR of the raw hsync and vsync. cs_o is inverted when pol_i[2]=1.
- R6: In mode 1, the eq_lines_i lines just before vsync and just after it carry an equalization pulse. It is active for pixel < eq_width_i and for pixel in [h_total_i/2, h_total_i/2+eq_width_i).
- R7: On vsync lines in modes 0 and 1, cs is active except at two serration notches, where pixel+serr_width_i >= h_total_i/2 with pixel < h_total_i/2, or pixel+serr_width_i >= h_total_i.
- R8: The configuration is captured on the first clock after reset and again at each frame end. Values changed at any other time have no effect until the next frame. Counting starts on the second clock after reset.
- R9: In slave mode, a rising edge on hs_in_i (a 1 after a 0 in the previous cycle) loads hs_dly_i into the pixel counter on that clock.
- R10: In slave mode, a rising edge on vs_in_i loads vs_dly_i into the line counter and sets the field to fid_in_i (forced to 0 when progressive).
- R11: In slave mode, when frame_lines_i+1 line ends pass with no vs_in_i rising edge, lock_lost_o goes to 1 and stays 1 until reset. Leaving slave mode clears the line count.
- R12: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Composite timing family |
| interlace_i | input | 1 | 1 = two fields per frame |
| slave_i | input | 1 | 1 = lock to external sync |
| pol_i | input | 3 | Polarity invert for hs, vs, cs |
| h_total_i | input | 12 | Pixels per line |
| hs_start_i | input | 12 | First pixel of hsync |
| hs_width_i | input | 12 | Hsync width in pixels |
| h_act_start_i | input | 12 | First active pixel |
| h_act_end_i | input | 12 | First blanked pixel after active |
| eq_width_i | input | 12 | Equalization pulse width |
| serr_width_i | input | 12 | Serration notch width |
| hs_dly_i | input | 12 | Pixel reload value on external hsync |
| f1_lines_i | input | 11 | Lines in field 0 |
| f2_lines_i | input | 11 | Lines in field 1 |
| frame_lines_i | input | 11 | Lock-loss window in lines |
| vs_start_i | input | 11 | First vsync line |
| vs_lines_i | input | 11 | Vsync length in lines |
| v_act_start_i | input | 11 | First active line |
| v_act_end_i | input | 11 | First blanked line after active |
| eq_lines_i | input | 11 | Equalization lines on each side of vsync |
| vs_dly_i | input | 11 | Line reload value on external vsync |
| hs_in_i | input | 1 | External horizontal sync |
| vs_in_i | input | 1 | External vertical sync |
| fid_in_i | input | 1 | External field identifier |
| hs_o | output | 1 | Horizontal sync |
| vs_o | output | 1 | Vertical sync |
| cs_o | output | 1 | Composite sync |
| fid_o | output | 1 | Field identifier |
| de_o | output | 1 | Active video enable |
| lock_lost_o | output | 1 | Sticky loss of external lock |

## Verification
The bench builds the block with its default widths: 12-bit pixel counts and 11-bit line counts. It programs small rasters of 16 to 32 pixels by 8 to 15 lines, so that a single run covers many frame ends, interlaced field changes, shadow reloads after mid-frame configuration changes, and all three composite families. An external sync stream that is deliberately longer than the programmed line drives real counter reloads. When that stream's vertical pulses are withheld, the lock-lost window is crossed within a few thousand cycles.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int HW = 12;
  localparam int VW = 11;

  typedef enum logic [1:0] {
    MODE_HD  = 2'd0,
    MODE_SD  = 2'd1,
    MODE_PC  = 2'd2,
    MODE_PC2 = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e          mode;
    logic           interlace;
    logic [2:0]     pol;
    logic [HW-1:0]  h_total;
    logic [HW-1:0]  hs_start;
    logic [HW-1:0]  hs_width;
    logic [HW-1:0]  h_act_start;
    logic [HW-1:0]  h_act_end;
    logic [HW-1:0]  eq_width;
    logic [HW-1:0]  serr_width;
    logic [HW-1:0]  hs_dly;
    logic [VW-1:0]  f1_lines;
    logic [VW-1:0]  f2_lines;
    logic [VW-1:0]  frame_lines;
    logic [VW-1:0]  vs_start;
    logic [VW-1:0]  vs_lines;
    logic [VW-1:0]  v_act_start;
    logic [VW-1:0]  v_act_end;
    logic [VW-1:0]  eq_lines;
    logic [VW-1:0]  vs_dly;
  } cfg_t;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow import vtg_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  input  logic frame_end_i,
  output cfg_t cfg_o,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      valid_o <= 1'b0;
    end else if (!valid_o || frame_end_i) begin
      cfg_o   <= cfg_i;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter import vtg_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic          valid_i,
  input  logic          slave_i,
  input  logic          hs_in_i,
  input  logic          vs_in_i,
  input  logic          fid_in_i,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          field_o,
  output logic          frame_end_o,
  output logic          hs_rise_o,
  output logic          vs_rise_o,
  output logic          lock_lost_o
);
  logic          hs_q, vs_q;
  logic          line_end, field_end;
  logic [VW-1:0] cur_lines;
  logic [HW-1:0] h_n;
  logic [VW-1:0] v_n;
  logic          f_n;
  logic [VW:0]   lines_since;

  assign hs_rise_o   = hs_in_i & ~hs_q;
  assign vs_rise_o   = vs_in_i & ~vs_q;
  assign cur_lines   = field_o ? cfg_i.f2_lines : cfg_i.f1_lines;
  assign line_end    = valid_i && (hcnt_o == cfg_i.h_total - HW'(1));
  assign field_end   = line_end && (vcnt_o == cur_lines - VW'(1));
  assign frame_end_o = field_end && (!cfg_i.interlace || field_o);

  always_comb begin
    h_n = line_end ? '0 : hcnt_o + HW'(1);
    v_n = vcnt_o;
    f_n = field_o;
    if (field_end) begin
      v_n = '0;
      f_n = cfg_i.interlace & ~field_o;
    end else if (line_end) begin
      v_n = vcnt_o + VW'(1);
    end
    // external edges override free-run values
    if (slave_i && hs_rise_o) h_n = cfg_i.hs_dly;
    if (slave_i && vs_rise_o) begin
      v_n = cfg_i.vs_dly;
      f_n = cfg_i.interlace & fid_in_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      hcnt_o  <= '0;
      vcnt_o  <= '0;
      field_o <= 1'b0;
    end else begin
      hs_q <= hs_in_i;
      vs_q <= vs_in_i;
      if (valid_i) begin
        hcnt_o  <= h_n;
        vcnt_o  <= v_n;
        field_o <= f_n;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_since <= '0;
      lock_lost_o <= 1'b0;
    end else begin
      if (!slave_i || vs_rise_o) lines_since <= '0;
      else if (line_end && lines_since != '1) lines_since <= lines_since + 1'b1;
      if (slave_i && line_end && !vs_rise_o && lines_since >= {1'b0, cfg_i.frame_lines})
        lock_lost_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode import vtg_pkg::*; (
  input  cfg_t          cfg_i,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] vcnt_i,
  input  logic          field_i,
  output logic          hs_o,
  output logic          vs_o,
  output logic          cs_o,
  output logic          fid_o,
  output logic          de_o
);
  logic [HW:0]   h, half, hs_end, eq_end, h_serr, tot;
  logic [VW+1:0] v, vs_beg, vs_end, pre_beg, post_end;
  logic          hs_raw, vs_raw, pre_eq, post_eq, eq_pulse, notch, cs_raw;

  always_comb begin
    h        = {1'b0, hcnt_i};
    tot      = {1'b0, cfg_i.h_total};
    half     = tot >> 1;
    hs_end   = {1'b0, cfg_i.hs_start} + {1'b0, cfg_i.hs_width};
    eq_end   = half + {1'b0, cfg_i.eq_width};
    h_serr   = h + {1'b0, cfg_i.serr_width};
    v        = {2'b0, vcnt_i};
    vs_beg   = {2'b0, cfg_i.vs_start};
    vs_end   = vs_beg + {2'b0, cfg_i.vs_lines};
    pre_beg  = v + {2'b0, cfg_i.eq_lines};
    post_end = vs_end + {2'b0, cfg_i.eq_lines};

    hs_raw   = (h >= {1'b0, cfg_i.hs_start}) && (h < hs_end);
    vs_raw   = (v >= vs_beg) && (v < vs_end);
    pre_eq   = (pre_beg >= vs_beg) && (v < vs_beg);
    post_eq  = (v >= vs_end) && (v < post_end);
    eq_pulse = (h < {1'b0, cfg_i.eq_width}) || ((h >= half) && (h < eq_end));
    notch    = ((h_serr >= half) && (h < half)) || (h_serr >= tot);

    unique case (cfg_i.mode)
      MODE_HD: cs_raw = vs_raw ? ~notch : hs_raw;
      MODE_SD: cs_raw = vs_raw ? ~notch : ((pre_eq || post_eq) ? eq_pulse : hs_raw);
      default: cs_raw = hs_raw | vs_raw;
    endcase

    hs_o  = hs_raw ^ cfg_i.pol[0];
    vs_o  = vs_raw ^ cfg_i.pol[1];
    cs_o  = cs_raw ^ cfg_i.pol[2];
    fid_o = field_i;
    de_o  = (hcnt_i >= cfg_i.h_act_start) && (hcnt_i < cfg_i.h_act_end) &&
            (vcnt_i >= cfg_i.v_act_start) && (vcnt_i < cfg_i.v_act_end);
  end
endmodule

// File: rtl/vtg_core.sv
module vtg_core import vtg_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          interlace_i,
  input  logic          slave_i,
  input  logic [2:0]    pol_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] hs_start_i,
  input  logic [HW-1:0] hs_width_i,
  input  logic [HW-1:0] h_act_start_i,
  input  logic [HW-1:0] h_act_end_i,
  input  logic [HW-1:0] eq_width_i,
  input  logic [HW-1:0] serr_width_i,
  input  logic [HW-1:0] hs_dly_i,
  input  logic [VW-1:0] f1_lines_i,
  input  logic [VW-1:0] f2_lines_i,
  input  logic [VW-1:0] frame_lines_i,
  input  logic [VW-1:0] vs_start_i,
  input  logic [VW-1:0] vs_lines_i,
  input  logic [VW-1:0] v_act_start_i,
  input  logic [VW-1:0] v_act_end_i,
  input  logic [VW-1:0] eq_lines_i,
  input  logic [VW-1:0] vs_dly_i,
  input  logic          hs_in_i,
  input  logic          vs_in_i,
  input  logic          fid_in_i,
  output logic          hs_o,
  output logic          vs_o,
  output logic          cs_o,
  output logic          fid_o,
  output logic          de_o,
  output logic          lock_lost_o
);
  cfg_t          cfg_live, cfg_q;
  logic          cfg_valid, frame_end, hs_rise, vs_rise, field;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  always_comb begin
    cfg_live             = '0;
    cfg_live.mode        = mode_e'(mode_i);
    cfg_live.interlace   = interlace_i;
    cfg_live.pol         = pol_i;
    cfg_live.h_total     = h_total_i;
    cfg_live.hs_start    = hs_start_i;
    cfg_live.hs_width    = hs_width_i;
    cfg_live.h_act_start = h_act_start_i;
    cfg_live.h_act_end   = h_act_end_i;
    cfg_live.eq_width    = eq_width_i;
    cfg_live.serr_width  = serr_width_i;
    cfg_live.hs_dly      = hs_dly_i;
    cfg_live.f1_lines    = f1_lines_i;
    cfg_live.f2_lines    = f2_lines_i;
    cfg_live.frame_lines = frame_lines_i;
    cfg_live.vs_start    = vs_start_i;
    cfg_live.vs_lines    = vs_lines_i;
    cfg_live.v_act_start = v_act_start_i;
    cfg_live.v_act_end   = v_act_end_i;
    cfg_live.eq_lines    = eq_lines_i;
    cfg_live.vs_dly      = vs_dly_i;
  end

  vtg_shadow u_shadow (
    .clk_i, .rst_ni, .cfg_i(cfg_live), .frame_end_i(frame_end),
    .cfg_o(cfg_q), .valid_o(cfg_valid)
  );

  vtg_counter u_cnt (
    .clk_i, .rst_ni, .cfg_i(cfg_q), .valid_i(cfg_valid), .slave_i,
    .hs_in_i, .vs_in_i, .fid_in_i,
    .hcnt_o(hcnt), .vcnt_o(vcnt), .field_o(field), .frame_end_o(frame_end),
    .hs_rise_o(hs_rise), .vs_rise_o(vs_rise), .lock_lost_o
  );

  vtg_decode u_dec (
    .cfg_i(cfg_q), .hcnt_i(hcnt), .vcnt_i(vcnt), .field_i(field),
    .hs_o, .vs_o, .cs_o, .fid_o, .de_o
  );
endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk import vtg_pkg::*; (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          slave_i,
  input logic          hs_rise_i,
  input logic          vs_rise_i,
  input logic          frame_end_i,
  input cfg_t          cfg_i,
  input logic [HW-1:0] hcnt_i,
  input logic [VW-1:0] vcnt_i,
  input logic          lock_lost_i
);
  p_hwrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && hcnt_i == cfg_i.h_total - HW'(1) && !(slave_i && hs_rise_i) |=> hcnt_i == '0);

  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !frame_end_i |=> $stable(cfg_i));

  p_hs_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && slave_i && hs_rise_i |=> hcnt_i == $past(cfg_i.hs_dly));

  p_vs_reload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && slave_i && vs_rise_i |=> vcnt_i == $past(cfg_i.vs_dly));

  p_lost_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lost_i |=> lock_lost_i);
endmodule

bind vtg_core vtg_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(cfg_valid), .slave_i(slave_i),
  .hs_rise_i(hs_rise), .vs_rise_i(vs_rise), .frame_end_i(frame_end),
  .cfg_i(cfg_q), .hcnt_i(hcnt), .vcnt_i(vcnt), .lock_lost_i(lock_lost_o)
);

// File: tb/vtg_core_tb_top.sv
module vtg_core_tb_top;
  import vtg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  cfg_t c = '0;
  logic slave = 1'b0, hs_in = 1'b0, vs_in = 1'b0, fid_in = 1'b0;
  logic hs, vs, cs, fid, de, lost;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  vtg_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(c.mode), .interlace_i(c.interlace),
    .slave_i(slave), .pol_i(c.pol), .h_total_i(c.h_total), .hs_start_i(c.hs_start),
    .hs_width_i(c.hs_width), .h_act_start_i(c.h_act_start), .h_act_end_i(c.h_act_end),
    .eq_width_i(c.eq_width), .serr_width_i(c.serr_width), .hs_dly_i(c.hs_dly),
    .f1_lines_i(c.f1_lines), .f2_lines_i(c.f2_lines), .frame_lines_i(c.frame_lines),
    .vs_start_i(c.vs_start), .vs_lines_i(c.vs_lines), .v_act_start_i(c.v_act_start),
    .v_act_end_i(c.v_act_end), .eq_lines_i(c.eq_lines), .vs_dly_i(c.vs_dly),
    .hs_in_i(hs_in), .vs_in_i(vs_in), .fid_in_i(fid_in),
    .hs_o(hs), .vs_o(vs), .cs_o(cs), .fid_o(fid), .de_o(de), .lock_lost_o(lost)
  );

  // reference model state, stepped from the requirements
  cfg_t mc;
  int   mh, mv, mcnt;
  logic mf, mvalid, mhq, mvq, mlost;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = '0; mh = 0; mv = 0; mf = 0; mvalid = 0; mhq = 0; mvq = 0; mcnt = 0; mlost = 0;
    end else begin
      logic hr, vr, le, fe_f, fe, nf;
      int   lines, nh, nv;
      hr    = hs_in & ~mhq;
      vr    = vs_in & ~mvq;
      le    = mvalid && (mh == int'(mc.h_total) - 1);
      lines = mf ? int'(mc.f2_lines) : int'(mc.f1_lines);
      fe_f  = le && (mv == lines - 1);
      fe    = fe_f && (!mc.interlace || mf);
      if (mvalid) begin
        nh = le ? 0 : mh + 1; nv = mv; nf = mf;
        if (fe_f) begin nv = 0; nf = mc.interlace & ~mf; end
        else if (le) nv = mv + 1;
        if (slave && hr) nh = int'(mc.hs_dly);
        if (slave && vr) begin nv = int'(mc.vs_dly); nf = mc.interlace & fid_in; end
        mh = nh; mv = nv; mf = nf;
      end
      if (slave && le && !vr && mcnt >= int'(mc.frame_lines)) mlost = 1;
      if (!slave || vr) mcnt = 0;
      else if (le) mcnt++;
      if (!mvalid || fe) mc = c;
      mvalid = 1;
      mhq = hs_in; mvq = vs_in;
    end
  end

  function automatic logic [4:0] model_out();
    int h = mh, v = mv, tot = int'(mc.h_total), half = int'(mc.h_total) / 2;
    int vse = int'(mc.vs_start) + int'(mc.vs_lines);
    logic hr, vr, pre, post, eqp, notch, csr;
    hr    = h >= int'(mc.hs_start) && h < int'(mc.hs_start) + int'(mc.hs_width);
    vr    = v >= int'(mc.vs_start) && v < vse;
    pre   = v < int'(mc.vs_start) && v + int'(mc.eq_lines) >= int'(mc.vs_start);
    post  = v >= vse && v < vse + int'(mc.eq_lines);
    eqp   = h < int'(mc.eq_width) || (h >= half && h < half + int'(mc.eq_width));
    notch = (h < half && h + int'(mc.serr_width) >= half) || (h + int'(mc.serr_width) >= tot);
    case (mc.mode)
      MODE_HD: csr = vr ? ~notch : hr;
      MODE_SD: csr = vr ? ~notch : ((pre || post) ? eqp : hr);
      default: csr = hr | vr;
    endcase
    return {hr ^ mc.pol[0], vr ^ mc.pol[1], csr ^ mc.pol[2], mf,
            h >= int'(mc.h_act_start) && h < int'(mc.h_act_end) &&
            v >= int'(mc.v_act_start) && v < int'(mc.v_act_end)};
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string phase);
    logic [4:0] e = model_out();
    chk({phase, " R3 hs"}, hs, e[4]);
    chk({phase, " R3 vs"}, vs, e[3]);
    chk({phase, " R5 cs"}, cs, e[2]);
    chk({phase, " R2 fid"}, fid, e[1]);
    chk({phase, " R4 de"}, de, e[0]);
    chk({phase, " R11 lost"}, lost, mlost);
  endtask

  function automatic cfg_t rand_cfg(int mode, bit il);
    cfg_t r = '0;
    int   ht = 16 + int'($urandom % 17);
    int   f1 = 8 + int'($urandom % 7);
    r.mode        = mode_e'(mode);
    r.interlace   = il;
    r.pol         = 3'($urandom % 8);
    r.h_total     = HW'(ht);
    r.hs_start    = HW'($urandom % (ht - 4));
    r.hs_width    = HW'(1 + $urandom % 3);
    r.h_act_start = HW'($urandom % 6);
    r.h_act_end   = HW'(ht - 1 - int'($urandom % 3));
    r.eq_width    = HW'(1 + $urandom % 3);
    r.serr_width  = HW'(2 + $urandom % 3);
    r.hs_dly      = HW'($urandom % ht);
    r.f1_lines    = VW'(f1);
    r.f2_lines    = VW'(f1 + int'($urandom % 2));
    r.frame_lines = il ? VW'(2 * f1 + 1) : VW'(f1);
    r.vs_start    = VW'(2 + $urandom % 2);
    r.vs_lines    = VW'(2 + $urandom % 2);
    r.v_act_start = r.vs_start + r.vs_lines + VW'(1 + $urandom % 2);
    r.v_act_end   = VW'(f1 - 1);
    r.eq_lines    = VW'(1 + $urandom % 2);
    r.vs_dly      = VW'($urandom % f1);
    return r;
  endfunction

  // runs n cycles; gen drives an external sync stream, vs_en gates its vertical pulses
  task automatic run(string phase, int n, bit gen, bit vs_en);
    int per_l = int'(c.h_total) + 3;
    int per_f = per_l * int'(c.f1_lines);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(phase);
      if (gen) begin
        hs_in = (i % per_l) < 2;
        if (vs_en && (i % per_f) == 0) fid_in = ~fid_in;
        vs_in = vs_en && ((i % per_f) < 3);
      end else begin
        hs_in = 0; vs_in = 0;
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    c = rand_cfg(0, 0);
    c.pol = 3'b111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R12 reset hs", hs, 0); chk("R12 reset vs", vs, 0);
      chk("R12 reset cs", cs, 0); chk("R12 reset fid", fid, 0);
      chk("R12 reset de", de, 0); chk("R12 reset lost", lost, 0);
    end
    rst_n = 1'b1;
    run("R1 first frame", 1200, 0, 0);
    // random geometries, swapped mid-frame so the shadow copy matters
    for (int k = 0; k < 12; k++) begin
      c = rand_cfg(k % 3, (k / 3) % 2 == 1);
      run((k % 3 == 1) ? "R8 R6 R7 sd" : "R8 R1 R7", 1300 + int'($urandom % 400), 0, 0);
    end
    // directed corner: equal-sized fields, all polarities active-high
    c = rand_cfg(1, 1);
    c.pol = 3'b000; c.f2_lines = c.f1_lines;
    run("R2 R6 interlace", 2500, 0, 0);
    // slave lock with a longer external line
    c = rand_cfg(1, 1);
    slave = 1'b1;
    run("R9 R10 slave", 4000, 1, 1);
    chk("R11 still locked", lost, 0);
    run("R11 vs withheld", 2500, 1, 0);
    chk("R11 lost raised", lost, 1);
    slave = 1'b0;
    run("R11 sticky master", 600, 0, 0);
    chk("R11 lost sticky", lost, 1);
    done = 1'b1;
    finish_run();
  end
endmodule